// File: doc/BRIEF.md
# Hit Cluster Width Filter

This block takes the one-bit-per-channel hit pattern of a single sensor layer after the discriminators. It samples the pattern on every bunch-crossing clock and groups adjacent hit channels into clusters. Clusters no wider than a programmable limit are passed on. Wider clusters, which usually come from low-momentum or very inclined tracks, are removed entirely. Hit bits from the neighbouring chips on both sides extend the pattern, so a cluster that crosses a chip boundary is measured at its true width. Those neighbour bits are used only for measuring and are never reported.

The result is a vector the same width as the local channel count. Depending on a mode input, it carries either every channel of the kept clusters or one marker per kept cluster at its centre channel. The output has a fixed latency of two clock cycles. Only adjacency within the one layer is considered. Channel mapping and correlation with the other layer happen elsewhere.

Top module: `hit_cluster_filter`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `out_o` is all zeros.
- R2: `out_o` reflects the inputs sampled two rising clock edges earlier; inputs applied for only one edge do not yet appear.
- R3: A cluster is a maximal run of adjacent hit channels. One or more unhit channels between two runs make them separate clusters, each with its own width.
- R4: `max_width_i` sets the widest cluster that is kept. Codes 1, 2 and 3 mean widths 1, 2 and 3, and code 0 means width 4. A cluster wider than the limit contributes no bit at all to `out_o`.
- R5: A run of five or more adjacent hits is always rejected, whatever the code.
- R6: `lo_edge_i` continues the pattern below channel 0. Bit NEDGE-1 is adjacent to channel 0 and bit 0 is the farthest. Its hits count toward the width of a cluster that touches channel 0.
- R7: `hi_edge_i` continues the pattern above channel NCH-1. Bit 0 is adjacent to channel NCH-1. Its hits count toward the width of a cluster that touches channel NCH-1.
- R8: A cluster made only of neighbour edge bits produces no output bit, and edge bits that are not adjacent to a local hit do not change `out_o`.
- R9: With `centre_mode_i` = 0, `out_o` has a 1 at every local channel of every kept cluster. With `centre_mode_i` = 1, each kept cluster gives a single 1 at index start + (width-1)/2, rounded down. This is the centre for odd widths and the lower of the two middle channels for even widths. The bit is given only when that index is a local channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hits_i | input | NCH | Local discriminated hits, bit k is channel k |
| lo_edge_i | input | NEDGE | Hits of the neighbour below; bit NEDGE-1 adjacent to channel 0 |
| hi_edge_i | input | NEDGE | Hits of the neighbour above; bit 0 adjacent to channel NCH-1 |
| max_width_i | input | 2 | Width limit code: 1..3 as is, 0 means 4 |
| centre_mode_i | input | 1 | 0 = pass kept hits, 1 = mark kept cluster centres |
| out_o | output | NCH | Filtered hit or centre vector, two cycles after input |

## Verification
The hardest case is a cluster whose width is decided by bits that do not belong to this chip. One example is a local run at channel 0 that becomes too wide only because of the lower neighbour's bits. Another is a centre that falls on an edge channel and so must disappear. The stimulus builds these cases directly by driving edge bits against runs at channels 0 and NCH-1, and sweeps every width code in both modes. Sparse random patterns, compared against a run-scanning model in the bench, then cover touching and closely spaced clusters.

// File: rtl/hcf_pkg.sv
package hcf_pkg;

    // Longest run that must be told apart from an acceptable one (limit max is 4).
    localparam int RUN_CAP = 5;
    localparam int RUN_W   = 3;

    typedef logic [RUN_W-1:0] run_t;

    typedef enum logic {
        MODE_KEEP   = 1'b0,
        MODE_CENTRE = 1'b1
    } out_mode_e;

    // Width limit code: 1..3 literal, 0 stands for the widest legal value, 4.
    function automatic run_t limit_decode(input logic [1:0] code);
        run_t lim;
        if (code == 2'd0) lim = run_t'(4);
        else              lim = {1'b0, code};
        return lim;
    endfunction

endpackage

// File: rtl/hcf_run_scan.sv
// Counts, for a slice of positions, how many consecutive hits start at each
// position and continue in one direction, saturating at RUN_CAP.
module hcf_run_scan
    import hcf_pkg::*;
#(
    parameter int EXT    = 134,
    parameter int OFS    = 3,
    parameter int NOUT   = 128,
    parameter bit UPWARD = 1'b1
) (
    input  logic [EXT-1:0]         vec_i,
    output run_t [NOUT-1:0]        run_o
);

    for (genvar p = 0; p < NOUT; p++) begin : g_pos
        logic [RUN_CAP-1:0] win;

        for (genvar k = 0; k < RUN_CAP; k++) begin : g_tap
            localparam int IDX = UPWARD ? (OFS + p + k) : (OFS + p - k);
            if (IDX >= 0 && IDX < EXT) begin : g_in
                assign win[k] = vec_i[IDX];
            end else begin : g_out
                assign win[k] = 1'b0;
            end
        end

        always_comb begin
            run_t cnt_d;
            logic alive_d;
            cnt_d   = '0;
            alive_d = 1'b1;
            for (int k = 0; k < RUN_CAP; k++) begin
                if (alive_d && win[k]) cnt_d = cnt_d + run_t'(1);
                else                   alive_d = 1'b0;
            end
            run_o[p] = cnt_d;
        end
    end

endmodule

// File: rtl/hcf_channel_judge.sv
// Per-channel decision: is this hit part of a kept cluster, and is it the
// marker channel of that cluster.
module hcf_channel_judge
    import hcf_pkg::*;
(
    input  logic      hit_i,
    input  run_t      run_dn_i,
    input  run_t      run_up_i,
    input  run_t      limit_i,
    input  out_mode_e mode_i,
    output logic      out_o
);

    logic [3:0] width;
    logic [3:0] width_m1;
    logic [3:0] pos_in_run;
    logic       keep;
    logic       centre;

    always_comb begin
        // Both runs include this channel itself when it is hit.
        width      = {1'b0, run_dn_i} + {1'b0, run_up_i} - 4'd1;
        width_m1   = width - 4'd1;
        pos_in_run = {1'b0, run_dn_i} - 4'd1;
        keep       = hit_i && (width <= {1'b0, limit_i});
        centre     = keep && (pos_in_run == (width_m1 >> 1));
        out_o      = (mode_i == MODE_CENTRE) ? centre : keep;
    end

endmodule

// File: rtl/hit_cluster_filter.sv
module hit_cluster_filter
    import hcf_pkg::*;
#(
    parameter int NCH   = 128,
    parameter int NEDGE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   hits_i,
    input  logic [NEDGE-1:0] lo_edge_i,
    input  logic [NEDGE-1:0] hi_edge_i,
    input  logic [1:0]       max_width_i,
    input  logic             centre_mode_i,
    output logic [NCH-1:0]   out_o
);

    localparam int EXT = NCH + 2 * NEDGE;

    typedef struct packed {
        logic [EXT-1:0] ext;
        run_t           limit;
        out_mode_e      mode;
        logic [NCH-1:0] out;
    } state_t;

    state_t st_d, st_q;

    run_t [NCH-1:0] run_dn;
    run_t [NCH-1:0] run_up;
    logic [NCH-1:0] judged;

    hcf_run_scan #(
        .EXT(EXT), .OFS(NEDGE), .NOUT(NCH), .UPWARD(1'b0)
    ) u_scan_dn (
        .vec_i (st_q.ext),
        .run_o (run_dn)
    );

    hcf_run_scan #(
        .EXT(EXT), .OFS(NEDGE), .NOUT(NCH), .UPWARD(1'b1)
    ) u_scan_up (
        .vec_i (st_q.ext),
        .run_o (run_up)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        hcf_channel_judge u_judge (
            .hit_i    (st_q.ext[NEDGE + c]),
            .run_dn_i (run_dn[c]),
            .run_up_i (run_up[c]),
            .limit_i  (st_q.limit),
            .mode_i   (st_q.mode),
            .out_o    (judged[c])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.ext   = {hi_edge_i, hits_i, lo_edge_i};
        st_d.limit = limit_decode(max_width_i);
        st_d.mode  = out_mode_e'(centre_mode_i);
        st_d.out   = judged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

endmodule

// File: rtl/hcf_checker.sv
module hcf_checker #(
    parameter int NCH = 128
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] hits_i,
    input logic [1:0]     max_width_i,
    input logic           centre_mode_i,
    input logic [NCH-1:0] out_o
);

    // R1: output still clear on the first edge after reset is released
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_o == '0));

    // R2: every output bit comes from a local hit two cycles earlier
    p_hit_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((out_o & ~$past(hits_i, 2)) == '0));

    // R9: centre markers of separate clusters never touch
    p_centre_sparse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(centre_mode_i, 2) |-> ((out_o & (out_o >> 1)) == '0));

    // R4: with a limit of one, no two kept channels are adjacent
    p_unit_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(max_width_i, 2) == 2'd1) |-> ((out_o & (out_o >> 1)) == '0));

endmodule

bind hit_cluster_filter hcf_checker #(.NCH(NCH)) u_hcf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .hits_i        (hits_i),
    .max_width_i   (max_width_i),
    .centre_mode_i (centre_mode_i),
    .out_o         (out_o)
);

// File: tb/hit_cluster_filter_bench.sv
module hit_cluster_filter_bench;

    localparam int NCH   = 128;
    localparam int NEDGE = 3;
    localparam int EXT   = NCH + 2 * NEDGE;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   hits_i = '0;
    logic [NEDGE-1:0] lo_edge_i = '0;
    logic [NEDGE-1:0] hi_edge_i = '0;
    logic [1:0]       max_width_i = 2'd0;
    logic             centre_mode_i = 1'b0;
    logic [NCH-1:0]   out_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    hit_cluster_filter #(.NCH(NCH), .NEDGE(NEDGE)) u_hit_cluster_filter (
        .clk           (clk),
        .rst_n         (rst_n),
        .hits_i        (hits_i),
        .lo_edge_i     (lo_edge_i),
        .hi_edge_i     (hi_edge_i),
        .max_width_i   (max_width_i),
        .centre_mode_i (centre_mode_i),
        .out_o         (out_o)
    );

    // Independent model: scan the extended pattern for maximal runs.
    function automatic logic [NCH-1:0] model(input logic [NCH-1:0] h,
                                             input logic [NEDGE-1:0] lo,
                                             input logic [NEDGE-1:0] hi,
                                             input logic [1:0] code,
                                             input logic centre);
        logic [EXT-1:0]  e;
        logic [NCH-1:0]  r;
        int lim;
        int j;
        e   = {hi, h, lo};
        r   = '0;
        lim = (code == 2'd0) ? 4 : int'(code);
        j   = 0;
        while (j < EXT) begin
            if (e[j]) begin
                int s;
                int w;
                s = j;
                while (j < EXT && e[j]) j++;
                w = j - s;
                if (w <= lim) begin
                    if (centre) begin
                        int c;
                        c = s + (w - 1) / 2 - NEDGE;
                        if (c >= 0 && c < NCH) r[c] = 1'b1;
                    end else begin
                        for (int p = s; p < s + w; p++)
                            if (p - NEDGE >= 0 && p - NEDGE < NCH) r[p - NEDGE] = 1'b1;
                    end
                end
            end else begin
                j++;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [NCH-1:0] got,
                         input logic [NCH-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [NCH-1:0] h, input logic [NEDGE-1:0] lo,
                         input logic [NEDGE-1:0] hi, input logic [1:0] code,
                         input logic centre);
        hits_i        = h;
        lo_edge_i     = lo;
        hi_edge_i     = hi;
        max_width_i   = code;
        centre_mode_i = centre;
    endtask

    // Drive at a falling edge, let two rising edges pass, sample at the next fall.
    task automatic run_case(input string req, input logic [NCH-1:0] h,
                            input logic [NEDGE-1:0] lo, input logic [NEDGE-1:0] hi,
                            input logic [1:0] code, input logic centre);
        @(negedge clk);
        drive(h, lo, hi, code, centre);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(req, out_o, model(h, lo, hi, code, centre));
    endtask

    task automatic t_reset;
        @(negedge clk);
        drive({NCH{1'b1}} ^ {(NCH/2){2'b10}}, '1, '1, 2'd1, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 during reset", out_o, '0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 first cycle after reset", out_o, '0);
    endtask

    task automatic t_singles;
        logic [NCH-1:0] h;
        h = '0;
        h[5] = 1'b1; h[10] = 1'b1; h[20] = 1'b1; h[NCH-2] = 1'b1;
        run_case("R3 isolated hits width 1", h, '0, '0, 2'd1, 1'b0);
        h[11] = 1'b1;
        run_case("R3 pair rejected beside kept single", h, '0, '0, 2'd1, 1'b0);
    endtask

    task automatic t_limits;
        logic [NCH-1:0] h;
        h = '0;
        h[8] = 1'b1;                                   // width 1
        h[20] = 1'b1; h[21] = 1'b1;                    // width 2
        h[40] = 1'b1; h[41] = 1'b1; h[42] = 1'b1;      // width 3
        for (int k = 60; k < 64; k++) h[k] = 1'b1;     // width 4
        for (int code = 0; code < 4; code++) begin
            run_case("R4 width limit, kept hits", h, '0, '0, 2'(code), 1'b0);
            run_case("R9 width limit, centre marks", h, '0, '0, 2'(code), 1'b1);
        end
    endtask

    task automatic t_wide;
        logic [NCH-1:0] h;
        h = '0;
        for (int k = 30; k < 35; k++) h[k] = 1'b1;     // width 5
        for (int k = 70; k < 76; k++) h[k] = 1'b1;     // width 6
        run_case("R5 long runs rejected", h, '0, '0, 2'd0, 1'b0);
        check("R5 long runs give zero", out_o, '0);
    endtask

    task automatic t_lo_edge;
        logic [NCH-1:0] h;
        h = '0;
        h[0] = 1'b1; h[1] = 1'b1;
        run_case("R6 lower edge makes width 3 over limit 2", h, 3'b100, '0, 2'd2, 1'b0);
        check("R6 boundary cluster suppressed", out_o, '0);
        run_case("R6 lower edge width 3 kept at limit 3", h, 3'b100, '0, 2'd3, 1'b0);
        run_case("R6 centre lands on channel 0", h, 3'b100, '0, 2'd3, 1'b1);
        run_case("R6 centre on edge bit is dropped", '0 | 1, 3'b110, '0, 2'd3, 1'b1);
        run_case("R6 far edge bit not adjacent", h, 3'b001, '0, 2'd2, 1'b0);
    endtask

    task automatic t_hi_edge;
        logic [NCH-1:0] h;
        h = '0;
        h[NCH-1] = 1'b1;
        run_case("R7 upper edge makes width 2 over limit 1", h, '0, 3'b001, 2'd1, 1'b0);
        run_case("R7 upper edge width 4 kept at code 0", h, '0, 3'b111, 2'd0, 1'b0);
        h[NCH-2] = 1'b1;
        run_case("R7 upper edge width 5 rejected", h, '0, 3'b111, 2'd0, 1'b0);
    endtask

    task automatic t_edge_only;
        logic [NCH-1:0] h;
        h = '0;
        run_case("R8 edge-only clusters not reported", h, 3'b111, 3'b011, 2'd3, 1'b1);
        check("R8 edge-only output zero", out_o, '0);
        h[3] = 1'b1;
        run_case("R8 non-adjacent edge bits no effect", h, 3'b011, 3'b110, 2'd1, 1'b0);
    endtask

    task automatic t_latency;
        logic [NCH-1:0] a;
        logic [NCH-1:0] b;
        a = '0; a[12] = 1'b1;
        b = '0; b[50] = 1'b1; b[51] = 1'b1;
        run_case("R2 steady first pattern", a, '0, '0, 2'd2, 1'b0);
        @(negedge clk);
        drive(b, '0, '0, 2'd2, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R2 one edge later still old", out_o, model(a, '0, '0, 2'd2, 1'b0));
        @(posedge clk);
        @(negedge clk);
        check("R2 two edges later new", out_o, model(b, '0, '0, 2'd2, 1'b0));
    endtask

    task automatic t_random;
        for (int n = 0; n < 24; n++) begin
            logic [NCH-1:0]   h;
            logic [NEDGE-1:0] lo;
            logic [NEDGE-1:0] hi;
            for (int w = 0; w < NCH / 32; w++)
                h[w*32 +: 32] = $urandom() & $urandom();
            lo = NEDGE'($urandom());
            hi = NEDGE'($urandom());
            run_case("R3 R9 random pattern", h, lo, hi, 2'($urandom()), 1'(n));
        end
    endtask

    initial begin
        void'($urandom(32'd7));
        t_reset();
        t_singles();
        t_limits();
        t_wide();
        t_lo_edge();
        t_hi_edge();
        t_edge_only();
        t_latency();
        t_random();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule